// File: doc/BRIEF.md
# Integer ALU with Overflow Detection

This block is the combinational integer execution unit of a small 32-bit RISC core. Each cycle the core hands it two register operands, a 5-bit shift count, a 16-bit immediate, an immediate-select bit and a 6-bit function code. The unit returns a 32-bit result and a signed-overflow flag. It covers addition and subtraction in both flagging and non-flagging forms, the four bitwise operations, three shifts, signed and unsigned less-than compares, and placing the immediate into the upper half of the result.

When `useImm` is high, the immediate replaces `opB` as the second operand. The unit widens the immediate itself. Logic operations pad it with zeros, and every other operation copies its top bit into the upper bits. The overflow flag is only reported. Trapping on it is left to the surrounding pipeline.

Function codes: add `100000`, add-no-flag `100001`, sub `100010`, sub-no-flag `100011`, AND `100100`, OR `100101`, XOR `100110`, NOR `100111`, shift-left `000000`, shift-right-logical `000010`, shift-right-arithmetic `000011`, less-than-signed `101010`, less-than-unsigned `101011`, upper-immediate `001111`.

Top module: `alu_core`

## Requirements
- R1: Codes `100000` and `100001` return the 32-bit wrapped sum of `opA` and the second operand.
- R2: Code `100000` raises `overflow` exactly when the two's-complement sum does not fit in 32 signed bits.
- R3: The no-flag codes `100001` and `100011` always hold `overflow` low. Their results still match the flagging forms.
- R4: Codes `100010` and `100011` return `opA` minus the second operand. Code `100010` raises `overflow` exactly when the signed difference does not fit in 32 bits.
- R5: Codes `100100`, `100101`, `100110` and `100111` return the bitwise AND, OR, XOR and NOR of `opA` and the second operand.
- R6: Code `000000` shifts the second operand left by `shiftAmt`, and code `000010` shifts it right by `shiftAmt`. In both, the vacated bits are zero.
- R7: Code `000011` shifts the second operand right by `shiftAmt` and fills the vacated bits with copies of its bit 31.
- R8: Code `101010` returns `0x00000001` when `opA` is less than the second operand as signed values, and `0x00000000` otherwise.
- R9: Code `101011` returns `0x00000001` when `opA` is less than the second operand as unsigned values, and `0x00000000` otherwise.
- R10: Code `001111` returns `imm` in bits 31..16 and zeros in bits 15..0, whatever the value of `useImm`.
- R11: With `useImm` high, the second operand is the immediate. Logic codes zero-extend it. Add, subtract and compare codes sign-extend it from bit 15.
- R12: Any function code not listed above returns a result of zero with `overflow` low.
- R13: `overflow` is low for every code other than `100000` and `100010`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 32 | First operand |
| opB | input | 32 | Second register operand |
| shiftAmt | input | 5 | Shift count |
| imm | input | 16 | Immediate field |
| useImm | input | 1 | Use the extended immediate as the second operand |
| funcSel | input | 6 | Function code |
| result | output | 32 | Operation result |
| overflow | output | 1 | Signed overflow of a flagging add or subtract |

## Verification
Addition and subtraction are driven with every pairing of 0, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF. These pairings separate true signed overflow from ordinary unsigned carry and borrow, and they show whether the flag is correctly suppressed for the no-flag codes. Compares use the same values, since 0x80000000 against 0x7FFFFFFF gives opposite answers when compared as signed and as unsigned. Shifts use operands whose top bit is set and clear, with counts of 0, 1, 31 and random values, which tells zero fill apart from sign fill. Immediates with bit 15 set distinguish zero extension from sign extension.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int FUNC_W = 6;

  localparam logic [FUNC_W-1:0] FN_ADD  = 6'b100000;
  localparam logic [FUNC_W-1:0] FN_ADDU = 6'b100001;
  localparam logic [FUNC_W-1:0] FN_SUB  = 6'b100010;
  localparam logic [FUNC_W-1:0] FN_SUBU = 6'b100011;
  localparam logic [FUNC_W-1:0] FN_AND  = 6'b100100;
  localparam logic [FUNC_W-1:0] FN_OR   = 6'b100101;
  localparam logic [FUNC_W-1:0] FN_XOR  = 6'b100110;
  localparam logic [FUNC_W-1:0] FN_NOR  = 6'b100111;
  localparam logic [FUNC_W-1:0] FN_SLL  = 6'b000000;
  localparam logic [FUNC_W-1:0] FN_SRL  = 6'b000010;
  localparam logic [FUNC_W-1:0] FN_SRA  = 6'b000011;
  localparam logic [FUNC_W-1:0] FN_SLT  = 6'b101010;
  localparam logic [FUNC_W-1:0] FN_SLTU = 6'b101011;
  localparam logic [FUNC_W-1:0] FN_LUI  = 6'b001111;

  typedef enum logic [1:0] {
    RS_ZERO,
    RS_ARITH,
    RS_LOGIC,
    RS_SHIFT
  } res_src_e;

  typedef enum logic [1:0] {
    LG_AND,
    LG_OR,
    LG_XOR,
    LG_NOR
  } logic_op_e;

  typedef enum logic [1:0] {
    SH_LEFT,
    SH_RIGHT_LOG,
    SH_RIGHT_ARI
  } shift_op_e;

  typedef enum logic [1:0] {
    AR_SUM,
    AR_LESS_S,
    AR_LESS_U,
    AR_UPPER
  } arith_out_e;

  typedef struct packed {
    res_src_e   resSrc;
    logic_op_e  logicOp;
    shift_op_e  shiftOp;
    arith_out_e arithOut;
    logic       invertB;
    logic       flagOvf;
    logic       zeroExt;
  } alu_strobe_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [FUNC_W-1:0] funcSel,
  output alu_strobe_t       strobe
);

  always_comb begin
    strobe          = '0;
    strobe.resSrc   = RS_ZERO;
    strobe.logicOp  = LG_AND;
    strobe.shiftOp  = SH_LEFT;
    strobe.arithOut = AR_SUM;
    unique case (funcSel)
      FN_ADD:  begin strobe.resSrc = RS_ARITH; strobe.flagOvf = 1'b1; end
      FN_ADDU: begin strobe.resSrc = RS_ARITH; end
      FN_SUB:  begin strobe.resSrc = RS_ARITH; strobe.invertB = 1'b1; strobe.flagOvf = 1'b1; end
      FN_SUBU: begin strobe.resSrc = RS_ARITH; strobe.invertB = 1'b1; end
      FN_AND:  begin strobe.resSrc = RS_LOGIC; strobe.logicOp = LG_AND; strobe.zeroExt = 1'b1; end
      FN_OR:   begin strobe.resSrc = RS_LOGIC; strobe.logicOp = LG_OR;  strobe.zeroExt = 1'b1; end
      FN_XOR:  begin strobe.resSrc = RS_LOGIC; strobe.logicOp = LG_XOR; strobe.zeroExt = 1'b1; end
      FN_NOR:  begin strobe.resSrc = RS_LOGIC; strobe.logicOp = LG_NOR; strobe.zeroExt = 1'b1; end
      FN_SLL:  begin strobe.resSrc = RS_SHIFT; strobe.shiftOp = SH_LEFT; end
      FN_SRL:  begin strobe.resSrc = RS_SHIFT; strobe.shiftOp = SH_RIGHT_LOG; end
      FN_SRA:  begin strobe.resSrc = RS_SHIFT; strobe.shiftOp = SH_RIGHT_ARI; end
      FN_SLT:  begin strobe.resSrc = RS_ARITH; strobe.invertB = 1'b1; strobe.arithOut = AR_LESS_S; end
      FN_SLTU: begin strobe.resSrc = RS_ARITH; strobe.invertB = 1'b1; strobe.arithOut = AR_LESS_U; end
      FN_LUI:  begin strobe.resSrc = RS_ARITH; strobe.arithOut = AR_UPPER; end
      default: begin strobe.resSrc = RS_ZERO; end
    endcase
  end

  // Only a flagging add or subtract may request the overflow report
  always_comb begin
    if (strobe.flagOvf) begin
      assert_flag_only_trapping_R13: assert (strobe.resSrc == RS_ARITH && strobe.arithOut == AR_SUM)
        else $error("flagOvf strobe on a non add/sub code");
    end
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  input  logic [SHAMT_W-1:0] shiftAmt,
  input  logic [IMM_W-1:0]   imm,
  input  logic               useImm,
  input  alu_strobe_t        strobe,
  output logic [DATA_W-1:0]  resOut,
  output logic               ovfOut
);

  localparam int MSB   = DATA_W - 1;
  localparam int EXT_W = DATA_W - IMM_W;

  // Second-operand selection with immediate widening
  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] secondOp;

  always_comb begin
    immExt   = strobe.zeroExt ? {{EXT_W{1'b0}}, imm} : {{EXT_W{imm[IMM_W-1]}}, imm};
    secondOp = useImm ? immExt : opB;
  end

  // Shared adder: subtract and compare reuse it through an inverted operand
  logic [DATA_W-1:0] addB;
  logic [DATA_W:0]   sumWide;
  logic [DATA_W-1:0] sumVal;
  logic              carryOut;
  logic              ovfRaw;
  logic              lessSigned;
  logic              lessUnsigned;

  always_comb begin
    addB         = strobe.invertB ? ~secondOp : secondOp;
    sumWide      = {1'b0, opA} + {1'b0, addB} + {{DATA_W{1'b0}}, strobe.invertB};
    sumVal       = sumWide[DATA_W-1:0];
    carryOut     = sumWide[DATA_W];
    ovfRaw       = (opA[MSB] == addB[MSB]) && (sumVal[MSB] != opA[MSB]);
    lessSigned   = sumVal[MSB] ^ ovfRaw;
    lessUnsigned = ~carryOut;
  end

  logic [DATA_W-1:0] arithRes;
  always_comb begin
    unique case (strobe.arithOut)
      AR_SUM:    arithRes = sumVal;
      AR_LESS_S: arithRes = {{(DATA_W-1){1'b0}}, lessSigned};
      AR_LESS_U: arithRes = {{(DATA_W-1){1'b0}}, lessUnsigned};
      default:   arithRes = {imm, {EXT_W{1'b0}}};
    endcase
  end

  // Bitwise unit
  logic [DATA_W-1:0] logicRes;
  always_comb begin
    unique case (strobe.logicOp)
      LG_AND:  logicRes = opA & secondOp;
      LG_OR:   logicRes = opA | secondOp;
      LG_XOR:  logicRes = opA ^ secondOp;
      default: logicRes = ~(opA | secondOp);
    endcase
  end

  // Log-depth right barrel shifter; left shifts ride on it through bit reversal
  logic              shLeft;
  logic              fillBit;
  logic [DATA_W-1:0] shIn;
  logic [DATA_W-1:0] shOutRaw;
  logic [DATA_W-1:0] shiftRes;
  logic [DATA_W-1:0] revIn;
  logic [DATA_W-1:0] revOut;
  logic [DATA_W-1:0] stage [SHAMT_W+1];

  always_comb begin
    shLeft  = (strobe.shiftOp == SH_LEFT);
    fillBit = (strobe.shiftOp == SH_RIGHT_ARI) ? secondOp[MSB] : 1'b0;
  end

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_rev
      assign revIn[gi]  = secondOp[MSB-gi];
      assign revOut[gi] = shOutRaw[MSB-gi];
    end
  endgenerate

  assign shIn     = shLeft ? revIn : secondOp;
  assign stage[0] = shIn;

  generate
    for (gi = 0; gi < SHAMT_W; gi++) begin : g_stage
      localparam int STEP = 1 << gi;
      assign stage[gi+1] = shiftAmt[gi]
        ? {{STEP{fillBit}}, stage[gi][DATA_W-1:STEP]}
        : stage[gi];
    end
  endgenerate

  assign shOutRaw = stage[SHAMT_W];
  assign shiftRes = shLeft ? revOut : shOutRaw;

  // Result steering
  always_comb begin
    unique case (strobe.resSrc)
      RS_ARITH: resOut = arithRes;
      RS_LOGIC: resOut = logicRes;
      RS_SHIFT: resOut = shiftRes;
      default:  resOut = '0;
    endcase
    ovfOut = strobe.flagOvf & ovfRaw;
  end

  // Compare results never carry data above bit 0
  always_comb begin
    if (strobe.resSrc == RS_ARITH && strobe.arithOut inside {AR_LESS_S, AR_LESS_U}) begin
      assert_compare_width_R8: assert (resOut[DATA_W-1:1] == '0)
        else $error("compare result has upper bits set");
    end
    if (strobe.resSrc == RS_ARITH && strobe.arithOut == AR_UPPER) begin
      assert_upper_low_clear_R10: assert (resOut[EXT_W-1:0] == '0)
        else $error("upper-immediate low half not clear");
    end
    if (strobe.resSrc == RS_SHIFT && strobe.shiftOp == SH_RIGHT_ARI && shiftAmt != '0) begin
      assert_sra_fill_R7: assert (resOut[MSB] == secondOp[MSB])
        else $error("arithmetic shift lost sign");
    end
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  input  logic [SHAMT_W-1:0] shiftAmt,
  input  logic [IMM_W-1:0]   imm,
  input  logic               useImm,
  input  logic [FUNC_W-1:0]  funcSel,
  output logic [DATA_W-1:0]  result,
  output logic               overflow
);

  alu_strobe_t strobe;

  alu_ctrl u_ctrl (
    .funcSel (funcSel),
    .strobe  (strobe)
  );

  alu_datapath #(
    .DATA_W  (DATA_W),
    .IMM_W   (IMM_W),
    .SHAMT_W (SHAMT_W)
  ) u_dp (
    .opA      (opA),
    .opB      (opB),
    .shiftAmt (shiftAmt),
    .imm      (imm),
    .useImm   (useImm),
    .strobe   (strobe),
    .resOut   (result),
    .ovfOut   (overflow)
  );

  always_comb begin
    if (funcSel == FN_ADDU || funcSel == FN_SUBU) begin
      assert_no_overflow_R3: assert (!overflow)
        else $error("no-flag form raised overflow");
    end
    if (funcSel != FN_ADD && funcSel != FN_SUB) begin
      assert_quiet_flag_R13: assert (!overflow)
        else $error("overflow on a non-flagging code");
    end
    if (strobe.resSrc == RS_ZERO) begin
      assert_unknown_zero_R12: assert (result == '0 && !overflow)
        else $error("unknown code produced output");
    end
  end

endmodule

// File: tb/alu_core_tb.sv
module alu_core_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [4:0]  shiftAmt = '0;
  logic [15:0] imm = '0;
  logic        useImm = 1'b0;
  logic [5:0]  funcSel = 6'b100000;
  logic [31:0] result;
  logic        overflow;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  alu_core u_dut (
    .opA      (opA),
    .opB      (opB),
    .shiftAmt (shiftAmt),
    .imm      (imm),
    .useImm   (useImm),
    .funcSel  (funcSel),
    .result   (result),
    .overflow (overflow)
  );

  logic [31:0] corners [4] = '{32'h0000_0000, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF};

  function automatic bit isLogic(input logic [5:0] f);
    return f inside {6'b100100, 6'b100101, 6'b100110, 6'b100111};
  endfunction

  function automatic void refModel(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b,
                                   input logic [4:0] sh, input logic [15:0] im, input bit ui,
                                   output logic [31:0] r, output bit v);
    logic [31:0] bb;
    longint wide;
    bb = ui ? (isLogic(f) ? {16'h0, im} : {{16{im[15]}}, im}) : b;
    v  = 1'b0;
    r  = '0;
    case (f)
      6'b100000, 6'b100001: begin
        wide = longint'($signed(a)) + longint'($signed(bb));
        r = a + bb;
        if (f == 6'b100000) v = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
      end
      6'b100010, 6'b100011: begin
        wide = longint'($signed(a)) - longint'($signed(bb));
        r = a - bb;
        if (f == 6'b100010) v = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
      end
      6'b100100: r = a & bb;
      6'b100101: r = a | bb;
      6'b100110: r = a ^ bb;
      6'b100111: r = ~(a | bb);
      6'b000000: r = bb << sh;
      6'b000010: r = bb >> sh;
      6'b000011: r = 32'($signed(bb) >>> sh);
      6'b101010: r = ($signed(a) < $signed(bb)) ? 32'd1 : 32'd0;
      6'b101011: r = (a < bb) ? 32'd1 : 32'd0;
      6'b001111: r = {im, 16'h0};
      default:   r = '0;
    endcase
  endfunction

  task automatic applyCheck(input string req, input logic [5:0] f, input logic [31:0] a,
                            input logic [31:0] b, input logic [4:0] sh, input logic [15:0] im,
                            input bit ui);
    logic [31:0] expR;
    bit expV;
    @(negedge clk);
    funcSel = f; opA = a; opB = b; shiftAmt = sh; imm = im; useImm = ui;
    refModel(f, a, b, sh, im, ui, expR, expV);
    #2;
    nChecks++;
    if (result !== expR || overflow !== expV) begin
      nFails++;
      $display("FAIL %s f=%b a=%h b=%h sh=%0d imm=%h ui=%0d: got %h/%0d expected %h/%0d",
               req, f, a, b, sh, im, ui, result, overflow, expR, expV);
    end
  endtask

  task automatic t_initial();
    // all inputs zero with add selected: zero sum, no flag (R1)
    #2;
    nChecks++;
    if (result !== 32'h0 || overflow !== 1'b0) begin
      nFails++;
      $display("FAIL R1 initial: got %h/%0d expected 00000000/0", result, overflow);
    end
  endtask

  task automatic t_add_sub();
    foreach (corners[i]) foreach (corners[j]) begin
      applyCheck("R1", 6'b100001, corners[i], corners[j], 0, 0, 0);
      applyCheck("R2", 6'b100000, corners[i], corners[j], 0, 0, 0);
      applyCheck("R3", 6'b100011, corners[i], corners[j], 0, 0, 0);
      applyCheck("R4", 6'b100010, corners[i], corners[j], 0, 0, 0);
    end
    for (int k = 0; k < 40; k++) begin
      applyCheck("R2", 6'b100000, $urandom, $urandom, 0, 0, 0);
      applyCheck("R4", 6'b100010, $urandom, $urandom, 0, 0, 0);
    end
  endtask

  task automatic t_logic();
    for (int k = 0; k < 10; k++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      applyCheck("R5", 6'b100100, a, b, 0, 0, 0);
      applyCheck("R5", 6'b100101, a, b, 0, 0, 0);
      applyCheck("R5", 6'b100110, a, b, 0, 0, 0);
      applyCheck("R5", 6'b100111, a, b, 0, 0, 0);
    end
  endtask

  task automatic t_shifts();
    logic [4:0] counts [4] = '{5'd0, 5'd1, 5'd31, 5'd13};
    foreach (counts[c]) begin
      applyCheck("R6", 6'b000000, 0, 32'hF000_000F, counts[c], 0, 0);
      applyCheck("R6", 6'b000010, 0, 32'hF000_000F, counts[c], 0, 0);
      applyCheck("R7", 6'b000011, 0, 32'hF000_000F, counts[c], 0, 0);
      applyCheck("R7", 6'b000011, 0, 32'h7000_000F, counts[c], 0, 0);
    end
    for (int k = 0; k < 10; k++) begin
      applyCheck("R6", 6'b000000, 0, $urandom, 5'($urandom), 0, 0);
      applyCheck("R7", 6'b000011, 0, $urandom, 5'($urandom), 0, 0);
    end
  endtask

  task automatic t_compare();
    foreach (corners[i]) foreach (corners[j]) begin
      applyCheck("R8", 6'b101010, corners[i], corners[j], 0, 0, 0);
      applyCheck("R9", 6'b101011, corners[i], corners[j], 0, 0, 0);
    end
  endtask

  task automatic t_upper();
    applyCheck("R10", 6'b001111, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 16'hABCD, 0);
    applyCheck("R10", 6'b001111, 32'h1234_5678, 0, 0, 16'h8001, 1);
  endtask

  task automatic t_immediate();
    applyCheck("R11", 6'b100000, 32'h0000_0010, 0, 0, 16'hFFFF, 1);
    applyCheck("R11", 6'b100000, 32'h8000_0000, 0, 0, 16'hFFFF, 1);
    applyCheck("R11", 6'b101010, 32'h0000_0000, 0, 0, 16'h8000, 1);
    applyCheck("R11", 6'b101011, 32'h7FFF_0000, 0, 0, 16'h8000, 1);
    applyCheck("R11", 6'b100100, 32'hFFFF_FFFF, 0, 0, 16'h8421, 1);
    applyCheck("R11", 6'b100101, 32'h0000_0000, 0, 0, 16'hF00F, 1);
    applyCheck("R11", 6'b100110, 32'hFFFF_0000, 0, 0, 16'hFFFF, 1);
  endtask

  task automatic t_unknown();
    applyCheck("R12", 6'b000001, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 3, 16'hFFFF, 0);
    applyCheck("R12", 6'b111111, 32'h7FFF_FFFF, 32'h0000_0001, 3, 16'hFFFF, 1);
    applyCheck("R12", 6'b001000, 32'h8000_0000, 32'hFFFF_FFFF, 3, 16'hFFFF, 0);
  endtask

  task automatic t_quiet_flag();
    applyCheck("R13", 6'b101010, 32'h7FFF_FFFF, 32'h8000_0000, 0, 0, 0);
    applyCheck("R13", 6'b100101, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 0, 0);
    applyCheck("R13", 6'b000000, 0, 32'h7FFF_FFFF, 1, 0, 0);
  endtask

  initial begin
    t_initial();
    repeat (2) @(posedge clk);
    rst = 1'b0;
    t_add_sub();
    t_logic();
    t_shifts();
    t_compare();
    t_upper();
    t_immediate();
    t_unknown();
    t_quiet_flag();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule